// File: doc/BRIEF.md
# Banked Stack Pointer Control Unit

This block keeps two physical stack pointers: a main pointer and a process pointer. It also keeps a two-bit control register. Together they present one architectural stack pointer to the datapath. The current execution mode, handler or thread, and one control bit decide which pointer is active. Stack writes, pushes and pops act only on the active pointer. Each push or pop moves the pointer by one 32-bit word.

The control register also holds a privilege-drop bit. While that bit is set, thread-mode code runs unprivileged, and its writes to the control register are discarded. Thread code therefore cannot restore its own privilege. The exception path has a separate write port that acts only in handler mode. Through that port the bit can be cleared, so that a return to thread mode resumes at privileged level.

During reset the main pointer loads a supplied initial value. The process pointer clears to zero, but software must not rely on that value. The low address bits of both pointers are forced to zero, so the active pointer is always word aligned.

Top module: `sp_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, a clock edge loads the main pointer with `init_sp` with its two low bits cleared and clears the control register. After reset, thread mode is privileged and the main pointer is active.
- R2: Control bit 1 selects the pointer in thread mode: 0 selects the main pointer, 1 selects the process pointer. The choice shows on `sp_out` in the cycle after the control write.
- R3: In handler mode `sp_out` shows the main pointer whatever control bit 1 holds. Pushes and pops in handler mode act on the main pointer.
- R4: The two low bits of `sp_out` always read as zero. A stack pointer write stores the written value with those two bits cleared.
- R5: While thread mode is unprivileged (control bit 0 set), a write on the software control port leaves the control register unchanged.
- R6: `priv_out` is 1 in handler mode regardless of control bit 0. In thread mode it is the inverse of control bit 0.
- R7: A push lowers the active pointer by 4 and a pop raises it by 4. The inactive pointer keeps its value.
- R8: A software control write in handler mode updates bit 0 only. Bit 1 keeps its value.
- R9: The exception-path control write loads both control bits in handler mode and is ignored in thread mode. It takes priority over a software write in the same cycle.
- R10: A stack pointer write takes priority over a push or pop in the same cycle. A push and a pop together leave the pointer unchanged.
- R11: Pointer arithmetic wraps modulo 2^32. A push from 0 gives 0xFFFFFFFC, and a pop from that value returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_sp | input | 32 | Main pointer value loaded during reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| sp_wr_en | input | 1 | Write the active stack pointer |
| sp_wr_data | input | 32 | Stack pointer write value |
| ctl_wr_en | input | 1 | Software control register write |
| ctl_wr_data | input | 2 | Software control value (bit 1 select, bit 0 privilege drop) |
| exc_ctl_wr_en | input | 1 | Exception-path control write |
| exc_ctl_wr_data | input | 2 | Exception-path control value |
| push | input | 1 | Decrement the active pointer by one word |
| pop | input | 1 | Increment the active pointer by one word |
| sp_out | output | 32 | Active architectural stack pointer |
| ctl_out | output | 2 | Control register readback |
| priv_out | output | 1 | Effective privilege, 1 = privileged |

## Verification
The bench builds the block with its default parameters: a 32-bit pointer width and two alignment bits, which gives a 4-byte step. With these values a few stack writes and pushes reach the wrap from 0 to 0xFFFFFFFC. They also show that a misaligned write lands on the word boundary. The two-bit control register is small enough to drive through every combination of mode, privilege and bank selection. This covers the one-way privilege drop and its recovery through the exception path.

// File: rtl/sp_bank_pkg.sv
`timescale 1ns/1ps
package sp_bank_pkg;
  // Control register layout: bit 1 picks the thread bank, bit 0 drops privilege.
  typedef struct packed {
    logic spsel;
    logic npriv;
  } ctl_t;

  localparam int NUM_BANKS = 2;
  localparam int BANK_MAIN = 0;
  localparam int BANK_PROC = 1;
endpackage

// File: rtl/sp_ctl_reg.sv
`timescale 1ns/1ps
module sp_ctl_reg
  import sp_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic handler_mode,
  input  logic sw_wr_en,
  input  ctl_t sw_wr_data,
  input  logic exc_wr_en,
  input  ctl_t exc_wr_data,
  output ctl_t ctl_q,
  output logic privileged,
  output logic use_psp,
  output logic sw_accept,
  output logic exc_accept
);
  ctl_t ctl_d;

  assign privileged = handler_mode | ~ctl_q.npriv;
  assign use_psp    = ~handler_mode & ctl_q.spsel;
  assign exc_accept = exc_wr_en & handler_mode;
  assign sw_accept  = sw_wr_en & privileged & ~exc_accept;

  always_comb begin
    ctl_d = ctl_q;
    if (exc_accept) begin
      ctl_d = exc_wr_data;
    end else if (sw_accept) begin
      ctl_d.npriv = sw_wr_data.npriv;
      if (!handler_mode) ctl_d.spsel = sw_wr_data.spsel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/sp_word_reg.sv
`timescale 1ns/1ps
module sp_word_reg #(
  parameter int SP_W      = 32,
  parameter int ALIGN_LSB = 2,
  parameter bit HAS_INIT  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SP_W-1:0] init_val,
  input  logic            active,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wr_data,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] q
);
  localparam logic [SP_W-1:0] LOW_MASK = SP_W'((1 << ALIGN_LSB) - 1);
  localparam logic [SP_W-1:0] STEP     = SP_W'(1) << ALIGN_LSB;

  function automatic logic [SP_W-1:0] align_word(input logic [SP_W-1:0] v);
    return v & ~LOW_MASK;
  endfunction

  function automatic logic [SP_W-1:0] next_ptr(input logic [SP_W-1:0] cur,
                                               input logic we,
                                               input logic [SP_W-1:0] wd,
                                               input logic dn,
                                               input logic up);
    if (we)            return align_word(wd);
    else if (dn && !up) return cur - STEP;
    else if (up && !dn) return cur + STEP;
    else               return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= HAS_INIT ? align_word(init_val) : '0;
    else if (active) q <= next_ptr(q, wr_en, wr_data, push, pop);
  end
endmodule

// File: rtl/sp_bank_ctrl.sv
`timescale 1ns/1ps
module sp_bank_ctrl
  import sp_bank_pkg::*;
#(
  parameter int SP_W      = 32,
  parameter int ALIGN_LSB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SP_W-1:0] init_sp,
  input  logic            handler_mode,
  input  logic            sp_wr_en,
  input  logic [SP_W-1:0] sp_wr_data,
  input  logic            ctl_wr_en,
  input  logic [1:0]      ctl_wr_data,
  input  logic            exc_ctl_wr_en,
  input  logic [1:0]      exc_ctl_wr_data,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp_out,
  output logic [1:0]      ctl_out,
  output logic            priv_out
);
  ctl_t ctl_q;
  logic use_psp;
  logic sw_accept;
  logic exc_accept;
  logic [SP_W-1:0] bank_q [NUM_BANKS];
  logic [SP_W-1:0] msp_q;
  logic [SP_W-1:0] psp_q;

  sp_ctl_reg u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .handler_mode(handler_mode),
    .sw_wr_en    (ctl_wr_en),
    .sw_wr_data  (ctl_t'(ctl_wr_data)),
    .exc_wr_en   (exc_ctl_wr_en),
    .exc_wr_data (ctl_t'(exc_ctl_wr_data)),
    .ctl_q       (ctl_q),
    .privileged  (priv_out),
    .use_psp     (use_psp),
    .sw_accept   (sw_accept),
    .exc_accept  (exc_accept)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (b == BANK_PROC) ? use_psp : ~use_psp;
    sp_word_reg #(
      .SP_W     (SP_W),
      .ALIGN_LSB(ALIGN_LSB),
      .HAS_INIT (b == BANK_MAIN)
    ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_val(init_sp),
      .active  (sel),
      .wr_en   (sp_wr_en),
      .wr_data (sp_wr_data),
      .push    (push),
      .pop     (pop),
      .q       (bank_q[b])
    );
  end

  assign msp_q   = bank_q[BANK_MAIN];
  assign psp_q   = bank_q[BANK_PROC];
  assign sp_out  = use_psp ? psp_q : msp_q;
  assign ctl_out = ctl_q;
endmodule

// File: rtl/sp_bank_ctrl_chk.sv
`timescale 1ns/1ps
module sp_bank_ctrl_chk #(
  parameter int SP_W      = 32,
  parameter int ALIGN_LSB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            handler_mode,
  input logic            sp_wr_en,
  input logic            ctl_wr_en,
  input logic            exc_ctl_wr_en,
  input logic            push,
  input logic            pop,
  input logic [SP_W-1:0] sp_out,
  input logic [1:0]      ctl_out,
  input logic            priv_out,
  input logic            use_psp,
  input logic [SP_W-1:0] msp_q
);
  localparam logic [SP_W-1:0] LOW_MASK = SP_W'((1 << ALIGN_LSB) - 1);
  localparam logic [SP_W-1:0] STEP     = SP_W'(1) << ALIGN_LSB;

  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_out & LOW_MASK) == '0);

  a_r6_handler_priv: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> priv_out);

  a_r3_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_out == msp_q);

  a_r5_unpriv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_out |=> ctl_out == $past(ctl_out));

  a_r8_handler_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_mode && !exc_ctl_wr_en) |=> ctl_out[1] == $past(ctl_out[1]));

  a_r9_thread_exc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && exc_ctl_wr_en && !ctl_wr_en) |=> $stable(ctl_out));

  a_r7_push_main: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !sp_wr_en && !use_psp) |=> msp_q == $past(msp_q) - STEP);
endmodule

bind sp_bank_ctrl sp_bank_ctrl_chk #(.SP_W(SP_W), .ALIGN_LSB(ALIGN_LSB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .handler_mode (handler_mode),
  .sp_wr_en     (sp_wr_en),
  .ctl_wr_en    (ctl_wr_en),
  .exc_ctl_wr_en(exc_ctl_wr_en),
  .push         (push),
  .pop          (pop),
  .sp_out       (sp_out),
  .ctl_out      (ctl_out),
  .priv_out     (priv_out),
  .use_psp      (use_psp),
  .msp_q        (msp_q)
);

// File: tb/sp_bank_ctrl_test.sv
`timescale 1ns/1ps
module sp_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] init_sp;
  logic        handler_mode, sp_wr_en, ctl_wr_en, exc_ctl_wr_en, push, pop;
  logic [31:0] sp_wr_data;
  logic [1:0]  ctl_wr_data, exc_ctl_wr_data;
  logic [31:0] sp_out;
  logic [1:0]  ctl_out;
  logic        priv_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] msp_m, psp_m;

  always #2 clk = ~clk;

  sp_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .init_sp(init_sp), .handler_mode(handler_mode),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .exc_ctl_wr_en(exc_ctl_wr_en),
    .exc_ctl_wr_data(exc_ctl_wr_data), .push(push), .pop(pop),
    .sp_out(sp_out), .ctl_out(ctl_out), .priv_out(priv_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    sp_wr_en = 0; ctl_wr_en = 0; exc_ctl_wr_en = 0; push = 0; pop = 0;
  endtask

  task automatic ctl_write(input logic [1:0] v);
    ctl_wr_en = 1; ctl_wr_data = v; step();
  endtask

  task automatic sp_write(input logic [31:0] v);
    sp_wr_en = 1; sp_wr_data = v; step();
  endtask

  task automatic t_reset();
    rst_n = 0; init_sp = 32'h2000_1003; handler_mode = 0;
    sp_wr_en = 0; ctl_wr_en = 0; exc_ctl_wr_en = 0; push = 0; pop = 0;
    sp_wr_data = '0; ctl_wr_data = '0; exc_ctl_wr_data = '0;
    repeat (3) step();
    rst_n = 1;
    msp_m = 32'h2000_1000;
    chk("R1 reset sp", sp_out, msp_m);
    chk("R1 reset ctl", {30'd0, ctl_out}, 32'd0);
    chk("R1 reset priv", {31'd0, priv_out}, 32'd1);
  endtask

  task automatic t_select();
    ctl_write(2'b10);
    chk("R2 ctl readback", {30'd0, ctl_out}, 32'd2);
    sp_write(32'h3000_0007);
    psp_m = 32'h3000_0004;
    chk("R2 R4 process pointer write", sp_out, psp_m);
    ctl_write(2'b00);
    chk("R2 back to main", sp_out, msp_m);
    sp_write(32'h2000_0FFF);
    msp_m = 32'h2000_0FFC;
    chk("R4 main aligned write", sp_out, msp_m);
  endtask

  task automatic t_push_pop();
    push = 1; step(); msp_m -= 4;
    chk("R7 push main", sp_out, msp_m);
    pop = 1; step(); pop = 1; step(); msp_m += 8;
    chk("R7 pop twice main", sp_out, msp_m);
    ctl_write(2'b10);
    chk("R7 process untouched", sp_out, psp_m);
    push = 1; step(); psp_m -= 4;
    chk("R7 push process", sp_out, psp_m);
    ctl_write(2'b00);
    chk("R7 main untouched", sp_out, msp_m);
  endtask

  task automatic t_handler();
    ctl_write(2'b10);
    handler_mode = 1; #1;
    chk("R3 handler shows main", sp_out, msp_m);
    push = 1; step(); msp_m -= 4;
    chk("R3 handler push main", sp_out, msp_m);
    ctl_write(2'b01);
    chk("R8 handler write keeps select", {30'd0, ctl_out}, 32'd3);
    chk("R6 handler privileged", {31'd0, priv_out}, 32'd1);
    ctl_write(2'b00);
    chk("R8 handler clears npriv only", {30'd0, ctl_out}, 32'd2);
    ctl_write(2'b01);
    handler_mode = 0; #1;
    chk("R6 thread unprivileged", {31'd0, priv_out}, 32'd0);
    chk("R2 thread process after handler", sp_out, psp_m);
  endtask

  task automatic t_unpriv();
    ctl_write(2'b00);
    chk("R5 unprivileged write dropped", {30'd0, ctl_out}, 32'd3);
    chk("R5 still unprivileged", {31'd0, priv_out}, 32'd0);
  endtask

  task automatic t_exc();
    exc_ctl_wr_en = 1; exc_ctl_wr_data = 2'b00; step();
    chk("R9 exc write ignored in thread", {30'd0, ctl_out}, 32'd3);
    handler_mode = 1; #1;
    exc_ctl_wr_en = 1; exc_ctl_wr_data = 2'b00;
    ctl_wr_en = 1; ctl_wr_data = 2'b01; step();
    chk("R9 exc write in handler wins", {30'd0, ctl_out}, 32'd0);
    handler_mode = 0; #1;
    chk("R9 privilege restored", {31'd0, priv_out}, 32'd1);
    chk("R9 main active after return", sp_out, msp_m);
  endtask

  task automatic t_priority();
    sp_wr_en = 1; sp_wr_data = 32'h4000_0010; push = 1; step();
    msp_m = 32'h4000_0010;
    chk("R10 write beats push", sp_out, msp_m);
    push = 1; pop = 1; step();
    chk("R10 push with pop no change", sp_out, msp_m);
  endtask

  task automatic t_wrap();
    sp_write(32'h0000_0000);
    push = 1; step();
    chk("R11 push wraps", sp_out, 32'hFFFF_FFFC);
    pop = 1; step();
    chk("R11 pop wraps back", sp_out, 32'h0000_0000);
  endtask

  initial begin
    t_reset();
    t_select();
    t_push_pop();
    t_handler();
    t_unpriv();
    t_exc();
    t_priority();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule